// File: doc/BRIEF.md
# Command Queue Feeder Channel

This block is a single request-driven transfer channel. It feeds 32-bit conversion commands from a queue held in system memory into the push register of a converter's command FIFO. Software first arms the channel with a queue start address, a queue length, a fixed destination register address, a restart address with its own length, and a mode bit. After that, every request from the peripheral moves exactly one command word. The word is read from the memory port at the current source pointer and written through the register write port to the destination. The requester then gets an acknowledge pulse.

After each transfer the source pointer moves to the next word and a down-counter tracks how many commands remain. When the last command has gone, the mode bit picks what happens next. In single-scan use the channel turns itself off and raises a done flag. In continuous use it reloads the pointer with the restart address and the counter with the restart length. The restart address can point back to the same queue, making it cyclic, or to a different queue. Requests that arrive while the channel is off have no effect.

The memory read port is synchronous: read data is valid in the cycle after the read strobe.

Top module: `cmdq_feeder`

## Requirements
- R1: Out of reset, `chan_on`, `scan_done`, `req_ack`, `mem_rd_en` and `reg_wr_en` are all 0.
- R2: A one-cycle `cfg_arm` with a nonzero `cfg_len` sets `chan_on` to 1 and `scan_done` to 0 from the next cycle. It captures the start address, length, restart address, restart length, mode bit and destination address.
- R3: A request seen while the channel is on and idle gives three strobes, each lasting one cycle and each one cycle after the previous. First `mem_rd_en` is high for one cycle with `mem_rd_addr` at the source pointer. Next `reg_wr_en` is high for one cycle, with `reg_wr_data` equal to the word the memory returned. Then `req_ack` is high for one cycle. Each request moves exactly one word.
- R4: `reg_wr_addr` equals the destination address captured at arming. Changing `cfg_dest_addr` without a new arm has no effect on it.
- R5: After each transfer that is not the last of its queue, the source pointer grows by 4 bytes.
- R6: With `cfg_wrap` = 0 when armed, the acknowledge of the last command is followed by `chan_on` = 0 and `scan_done` = 1. Later requests produce no memory read and no acknowledge.
- R7: With `cfg_wrap` = 1 when armed, the transfer after the last command reads the captured restart address. The channel then counts the captured restart length before it reloads again, and `chan_on` stays 1.
- R8: While `chan_on` is 0, requests produce no memory read, no register write and no acknowledge.
- R9: Arming clears `scan_done`.
- R10: Arming with `cfg_len` = 0 leaves `chan_on` at 0 and clears `scan_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_arm | input | 1 | One-cycle pulse that captures the configuration and (re)starts the channel |
| cfg_start_addr | input | 32 | Byte address of the first command of the queue |
| cfg_len | input | 16 | Number of commands in the queue |
| cfg_restart_addr | input | 32 | Byte address loaded at end of queue in continuous mode |
| cfg_restart_len | input | 16 | Command count loaded at end of queue in continuous mode |
| cfg_dest_addr | input | 32 | Address of the FIFO push register |
| cfg_wrap | input | 1 | 1 = reload at end of queue, 0 = turn off at end of queue |
| req | input | 1 | Transfer request level, held until acknowledged |
| req_ack | output | 1 | One-cycle acknowledge after the write |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 32 | Memory read byte address |
| mem_rd_data | input | 32 | Memory read data, valid the cycle after the strobe |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_addr | output | 32 | Register write address (fixed destination) |
| reg_wr_data | output | 32 | Register write data |
| chan_on | output | 1 | Channel is armed and serving requests |
| scan_done | output | 1 | Channel turned itself off at the end of a queue |

## Verification
The hardest situation to reach from the ports is the end-of-queue decision. The last command of a queue must be told apart from the others, and in continuous mode the channel must be shown to reload the pointer and also to count the new restart length correctly, not the old one. The stimulus arms a two-word queue whose restart target is a three-word queue at another address. It then runs enough requests to pass two reload points, checking every read address in turn. A separate single-scan run drives requests after the channel has turned itself off and confirms that the memory and acknowledge strobes stay quiet.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

    typedef enum logic [1:0] {
        XF_IDLE  = 2'd0,
        XF_READ  = 2'd1,
        XF_WRITE = 2'd2,
        XF_ACK   = 2'd3
    } xfer_state_e;

endpackage

// File: rtl/cmdq_src_ptr.sv
module cmdq_src_ptr #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int STEP_B = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  start_len,
    input  logic [ADDR_W-1:0] restart_addr,
    input  logic [LEN_W-1:0]  restart_len,
    input  logic              wrap_mode,
    input  logic              step,
    output logic [ADDR_W-1:0] src_addr,
    output logic              active,
    output logic              done
);

    localparam logic [ADDR_W-1:0] INC   = ADDR_W'(STEP_B);
    localparam logic [LEN_W-1:0]  ONE_L = LEN_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [LEN_W-1:0]  left;
        logic [ADDR_W-1:0] rs_addr;
        logic [LEN_W-1:0]  rs_len;
        logic              wrap;
        logic              active;
        logic              done;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic at_last;

    assign at_last = (ptr_q.left <= ONE_L);

    always_comb begin
        ptr_d = ptr_q;
        if (arm) begin
            ptr_d.src     = start_addr;
            ptr_d.left    = start_len;
            ptr_d.rs_addr = restart_addr;
            ptr_d.rs_len  = restart_len;
            ptr_d.wrap    = wrap_mode;
            ptr_d.active  = (start_len != '0);
            ptr_d.done    = 1'b0;
        end else if (step && ptr_q.active) begin
            if (at_last) begin
                if (ptr_q.wrap && (ptr_q.rs_len != '0)) begin
                    ptr_d.src  = ptr_q.rs_addr;
                    ptr_d.left = ptr_q.rs_len;
                end else begin
                    ptr_d.active = 1'b0;
                    ptr_d.done   = 1'b1;
                end
            end else begin
                ptr_d.src  = ptr_q.src + INC;
                ptr_d.left = ptr_q.left - ONE_L;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign src_addr = ptr_q.src;
    assign active   = ptr_q.active;
    assign done     = ptr_q.done;

    // R5: a mid-queue step moves the pointer by one word
    a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (step && ptr_q.active && !at_last && !arm) |=> (ptr_q.src == $past(ptr_q.src) + INC));

    // R7: an end-of-queue step in continuous mode jumps to the restart address
    a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (step && ptr_q.active && at_last && ptr_q.wrap && (ptr_q.rs_len != '0) && !arm)
        |=> (ptr_q.src == $past(ptr_q.rs_addr) && ptr_q.active));

    // R6: done is only ever seen with the channel off
    a_r6_done_off: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !active);

    // R9: arming always leaves done cleared
    a_r9_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> !done);

endmodule

// File: rtl/cmdq_xfer_fsm.sv
module cmdq_xfer_fsm
    import cmdq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic active,
    output logic rd_en,
    output logic wr_en,
    output logic ack,
    output logic step
);

    typedef struct packed {
        xfer_state_e st;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            XF_IDLE:  if (req && active) fsm_d.st = XF_READ;
            XF_READ:  fsm_d.st = XF_WRITE;
            XF_WRITE: fsm_d.st = XF_ACK;
            XF_ACK:   fsm_d.st = XF_IDLE;
            default:  fsm_d.st = XF_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q.st <= XF_IDLE;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign rd_en = (fsm_q.st == XF_READ);
    assign wr_en = (fsm_q.st == XF_WRITE);
    assign ack   = (fsm_q.st == XF_ACK);
    assign step  = wr_en;

    // R3: the write follows the read by one cycle
    a_r3_rd_then_wr: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> wr_en);

    // R3: the acknowledge follows the write by one cycle
    a_r3_wr_then_ack: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ack);

    // R3: the acknowledge is a single-cycle pulse
    a_r3_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R8: an idle channel that is off never starts a read
    a_r8_off_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == XF_IDLE && !active) |=> !rd_en);

endmodule

// File: rtl/cmdq_feeder.sv
module cmdq_feeder #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_arm,
    input  logic [ADDR_W-1:0] cfg_start_addr,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [ADDR_W-1:0] cfg_restart_addr,
    input  logic [LEN_W-1:0]  cfg_restart_len,
    input  logic [ADDR_W-1:0] cfg_dest_addr,
    input  logic              cfg_wrap,
    input  logic              req,
    output logic              req_ack,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              reg_wr_en,
    output logic [ADDR_W-1:0] reg_wr_addr,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic              chan_on,
    output logic              scan_done
);

    localparam int STEP_B = DATA_W / 8;

    logic              step;
    logic              active;
    logic [ADDR_W-1:0] src_addr;
    logic [ADDR_W-1:0] dest_d, dest_q;

    cmdq_src_ptr #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .STEP_B (STEP_B)
    ) i_ptr (
        .clk          (clk),
        .rst_n        (rst_n),
        .arm          (cfg_arm),
        .start_addr   (cfg_start_addr),
        .start_len    (cfg_len),
        .restart_addr (cfg_restart_addr),
        .restart_len  (cfg_restart_len),
        .wrap_mode    (cfg_wrap),
        .step         (step),
        .src_addr     (src_addr),
        .active       (active),
        .done         (scan_done)
    );

    cmdq_xfer_fsm i_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .active (active),
        .rd_en  (mem_rd_en),
        .wr_en  (reg_wr_en),
        .ack    (req_ack),
        .step   (step)
    );

    always_comb begin
        dest_d = dest_q;
        if (cfg_arm) begin
            dest_d = cfg_dest_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dest_q <= '0;
        end else begin
            dest_q <= dest_d;
        end
    end

    assign mem_rd_addr = src_addr;
    assign reg_wr_addr = dest_q;
    assign reg_wr_data = mem_rd_data;
    assign chan_on     = active;

    // R4: the destination only moves on an arm
    a_r4_dest_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_arm |=> $stable(reg_wr_addr));

    // R3: the read address holds steady between read and write
    a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && !cfg_arm) |=> $stable(mem_rd_addr));

endmodule

// File: tb/test_cmdq_feeder.sv
module test_cmdq_feeder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_arm = 1'b0;
    logic [31:0] cfg_start_addr = '0;
    logic [15:0] cfg_len = '0;
    logic [31:0] cfg_restart_addr = '0;
    logic [15:0] cfg_restart_len = '0;
    logic [31:0] cfg_dest_addr = '0;
    logic        cfg_wrap = 1'b0;
    logic        req = 1'b0;
    logic        req_ack;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic [31:0] mem_rd_data = '0;
    logic        reg_wr_en;
    logic [31:0] reg_wr_addr;
    logic [31:0] reg_wr_data;
    logic        chan_on;
    logic        scan_done;

    int n_chk = 0;
    int n_bad = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int ack_cnt = 0;
    logic [31:0] last_rd_addr = '0;
    logic [31:0] last_wr_addr = '0;
    logic [31:0] last_wr_data = '0;

    always #10 clk = ~clk;

    cmdq_feeder i_cmdq_feeder (
        .clk(clk), .rst_n(rst_n), .cfg_arm(cfg_arm),
        .cfg_start_addr(cfg_start_addr), .cfg_len(cfg_len),
        .cfg_restart_addr(cfg_restart_addr), .cfg_restart_len(cfg_restart_len),
        .cfg_dest_addr(cfg_dest_addr), .cfg_wrap(cfg_wrap),
        .req(req), .req_ack(req_ack),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .chan_on(chan_on), .scan_done(scan_done)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {16'hC0DE, a[15:0] ^ 16'h5A00};
    endfunction

    // synchronous memory model: data valid the cycle after the strobe
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= pat(mem_rd_addr);
    end

    always @(negedge clk) begin
        if (mem_rd_en) begin rd_cnt++; last_rd_addr = mem_rd_addr; end
        if (reg_wr_en) begin wr_cnt++; last_wr_addr = reg_wr_addr; last_wr_data = reg_wr_data; end
        if (req_ack) ack_cnt++;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic arm(input logic [31:0] sa, input logic [15:0] ln,
                       input logic [31:0] ra, input logic [15:0] rl,
                       input logic [31:0] da, input logic wr);
        @(negedge clk);
        cfg_start_addr = sa; cfg_len = ln; cfg_restart_addr = ra;
        cfg_restart_len = rl; cfg_dest_addr = da; cfg_wrap = wr; cfg_arm = 1'b1;
        @(negedge clk);
        cfg_arm = 1'b0;
    endtask

    task automatic do_req(input logic [31:0] exp_rd, input logic [31:0] exp_dst, input string tag);
        bit seen;
        seen = 0;
        @(negedge clk);
        req = 1'b1;
        for (int i = 0; i < 20 && !seen; i++) begin
            @(negedge clk);
            if (req_ack) seen = 1;
        end
        req = 1'b0;
        check({tag, " ack seen"}, 32'(seen), 32'd1);
        check({tag, " read addr"}, last_rd_addr, exp_rd);
        check({tag, " write addr"}, last_wr_addr, exp_dst);
        check({tag, " write data"}, last_wr_data, pat(exp_rd));
    endtask

    task automatic t_reset;
        check("R1 chan_on", 32'(chan_on), 0);
        check("R1 scan_done", 32'(scan_done), 0);
        check("R1 req_ack", 32'(req_ack), 0);
        check("R1 mem_rd_en", 32'(mem_rd_en), 0);
        check("R1 reg_wr_en", 32'(reg_wr_en), 0);
    endtask

    task automatic t_ignored(input string tag);
        int r0, a0, w0;
        r0 = rd_cnt; a0 = ack_cnt; w0 = wr_cnt;
        @(negedge clk);
        req = 1'b1;
        repeat (10) @(negedge clk);
        req = 1'b0;
        check({tag, " no read"}, 32'(rd_cnt), 32'(r0));
        check({tag, " no write"}, 32'(wr_cnt), 32'(w0));
        check({tag, " no ack"}, 32'(ack_cnt), 32'(a0));
    endtask

    task automatic t_single_scan;
        arm(32'h100, 16'd3, 32'h200, 16'd2, 32'h4000_0010, 1'b0);
        check("R2 chan_on after arm", 32'(chan_on), 1);
        check("R2 scan_done after arm", 32'(scan_done), 0);
        // cycle-exact first request
        req = 1'b1;
        @(negedge clk);
        check("R3 rd strobe", 32'(mem_rd_en), 1);
        check("R3 rd addr", mem_rd_addr, 32'h100);
        check("R3 no early write", 32'(reg_wr_en), 0);
        @(negedge clk);
        check("R3 wr strobe", 32'(reg_wr_en), 1);
        check("R3 rd strobe single", 32'(mem_rd_en), 0);
        check("R3 wr data", reg_wr_data, pat(32'h100));
        check("R4 wr addr", reg_wr_addr, 32'h4000_0010);
        @(negedge clk);
        check("R3 ack strobe", 32'(req_ack), 1);
        check("R3 wr strobe single", 32'(reg_wr_en), 0);
        req = 1'b0;
        @(negedge clk);
        check("R3 ack single", 32'(req_ack), 0);
        check("R3 one word per request", 32'(wr_cnt), 1);
        cfg_dest_addr = 32'h4000_0099;
        do_req(32'h104, 32'h4000_0010, "R5 R4 second");
        check("R6 on before last", 32'(chan_on), 1);
        do_req(32'h108, 32'h4000_0010, "R5 third");
        @(negedge clk);
        check("R6 chan off", 32'(chan_on), 0);
        check("R6 done set", 32'(scan_done), 1);
        t_ignored("R6 R8 after self-off");
    endtask

    task automatic t_wrap;
        arm(32'h300, 16'd2, 32'h380, 16'd3, 32'h4000_0020, 1'b1);
        check("R9 done cleared", 32'(scan_done), 0);
        check("R2 chan_on wrap", 32'(chan_on), 1);
        do_req(32'h300, 32'h4000_0020, "R7 q0");
        do_req(32'h304, 32'h4000_0020, "R7 q1");
        do_req(32'h380, 32'h4000_0020, "R7 r0");
        do_req(32'h384, 32'h4000_0020, "R7 r1");
        do_req(32'h388, 32'h4000_0020, "R7 r2");
        do_req(32'h380, 32'h4000_0020, "R7 second reload");
        @(negedge clk);
        check("R7 still on", 32'(chan_on), 1);
        check("R7 no done", 32'(scan_done), 0);
    endtask

    task automatic t_zero_len;
        arm(32'h500, 16'd0, 32'h600, 16'd1, 32'h4000_0030, 1'b1);
        check("R10 chan off", 32'(chan_on), 0);
        check("R10 done clear", 32'(scan_done), 0);
        t_ignored("R8 zero length");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ignored("R8 before arm");
        t_single_scan();
        t_wrap();
        t_zero_len();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R3 watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule